// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Level Triggers and Interrupt

This block buffers audio samples in two directions between a host side and a serial-interface side. A transmit queue takes samples pushed by the host and hands them, oldest first, to the serializer when it pops. A receive queue takes samples pushed by the deserializer and hands them to the host. The host pops a receive sample when it is done with it, and it can read the oldest one at any time without removing it.

Around the two queues sit the signals that pace the data stream. Each queue has a programmable level trigger. The transmit trigger becomes active once the fill level has fallen to a threshold. The receive trigger becomes active once the fill level has risen above a threshold. Each direction also has a sticky error flag, cleared by writing a one. Separate set and clear strobes control a four-bit interrupt enable. The block produces one registered interrupt line and two DMA request lines. A flush strobe per direction empties that queue at once.

Top module: `fifo_lvl_irq`

## Requirements
- R1: Each queue holds up to DEPTH (16) entries. It reports its fill level as a count from 0 to 16 and returns entries in push order. Four flags are derived from the levels: tx_empty when the TX level is 0, tx_not_full when the TX level is below 16, rx_not_empty when the RX level is above 0, and rx_full when the RX level equals 16.
- R2: The TX level flag is active while tx_lvl_en is 1 and the TX level is at or below tx_thr. A threshold of 0 means the queue is empty; 15 means it is no longer full.
- R3: The RX level flag is active while rx_lvl_en is 1 and the RX level is at or above rx_thr + 1. A threshold of 0 means one entry is present; 15 means the queue is full.
- R4: A host push into a full TX queue or a serializer pop from an empty TX queue sets tx_err. A deserializer push into a full RX queue sets rx_err. A push into a full queue is dropped. Both flags hold their value until they are cleared.
- R5: err_clr bit 0 clears tx_err and bit 1 clears rx_err. If a new error occurs in the same cycle as the clear, the flag stays set.
- R6: ien bit 0 enables the TX error source, bit 1 the RX error source, bit 2 the TX level source and bit 3 the RX level source. A 1 on ien_set sets the matching bit and a 1 on ien_clr clears it. If both strobes are 1 for the same bit in the same cycle, the set wins.
- R7: int_stat = {rx level flag, tx level flag, rx_err, tx_err} & ien, evaluated combinationally.
- R8: irq equals the OR of int_stat from the previous clock cycle.
- R9: dma_tx_req = dma_tx_en AND the TX queue is not full. dma_rx_req = dma_rx_en AND the RX queue is not empty.
- R10: A flush strobe empties its queue at the next clock edge. If a push arrives in the same cycle as the flush, the queue is still empty afterwards, the push is discarded and no error is recorded.
- R11: rx_head shows the oldest RX entry and tx_head the oldest TX entry. Reading either does not remove the entry; only a pop does.
- R12: A push and a pop on the same queue in the same cycle, when the queue is neither empty nor full, leave its level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_push | input | 1 | Host writes a sample into the TX queue |
| host_wdata | input | DW | Sample written by the host |
| host_pop | input | 1 | Host removes the RX head |
| rx_head | output | DW | Oldest RX entry (read without removal) |
| per_pop | input | 1 | Serializer removes the TX head |
| tx_head | output | DW | Oldest TX entry |
| per_push | input | 1 | Deserializer writes a sample into the RX queue |
| per_wdata | input | DW | Sample from the deserializer |
| tx_flush | input | 1 | Empty the TX queue |
| rx_flush | input | 1 | Empty the RX queue |
| tx_thr | input | AW | TX trigger threshold |
| rx_thr | input | AW | RX trigger threshold (minus one) |
| tx_lvl_en | input | 1 | TX level trigger enable |
| rx_lvl_en | input | 1 | RX level trigger enable |
| dma_tx_en | input | 1 | TX DMA request enable |
| dma_rx_en | input | 1 | RX DMA request enable |
| err_clr | input | 2 | Write-one-to-clear for {rx_err, tx_err} |
| ien_set | input | 4 | Interrupt enable set strobes |
| ien_clr | input | 4 | Interrupt enable clear strobes |
| tx_level | output | LW | TX fill level |
| rx_level | output | LW | RX fill level |
| tx_empty | output | 1 | TX level is 0 |
| tx_not_full | output | 1 | TX level below DEPTH |
| rx_not_empty | output | 1 | RX level above 0 |
| rx_full | output | 1 | RX level equals DEPTH |
| tx_err | output | 1 | Sticky TX error |
| rx_err | output | 1 | Sticky RX error |
| ien | output | 4 | Current interrupt enables |
| int_stat | output | 4 | Enabled interrupt sources |
| irq | output | 1 | Registered interrupt line |
| dma_tx_req | output | 1 | TX DMA request |
| dma_rx_req | output | 1 | RX DMA request |

## Verification
The risky coincidences are a flush landing in the same cycle as a push, and an error being raised in the same cycle as its write-one clear. A push and a pop on the same queue in one cycle is a third. The bench drives each of these pairs deliberately. It flushes while pushing, and it clears the TX error while pushing into a full queue. In the next cycle it checks that the level is zero with no error recorded, and that the error flag is still set. A long random phase then lets flushes, clears, pushes, pops and enable strobes collide freely. A queue-based model judges every cycle.

// File: rtl/fifo_lvl_irq.sv
module fifo_lvl_irq #(
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_push,
  input  logic [DW-1:0] host_wdata,
  input  logic          host_pop,
  output logic [DW-1:0] rx_head,
  input  logic          per_pop,
  output logic [DW-1:0] tx_head,
  input  logic          per_push,
  input  logic [DW-1:0] per_wdata,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic [AW-1:0] tx_thr,
  input  logic [AW-1:0] rx_thr,
  input  logic          tx_lvl_en,
  input  logic          rx_lvl_en,
  input  logic          dma_tx_en,
  input  logic          dma_rx_en,
  input  logic [1:0]    err_clr,
  input  logic [3:0]    ien_set,
  input  logic [3:0]    ien_clr,
  output logic [LW-1:0] tx_level,
  output logic [LW-1:0] rx_level,
  output logic          tx_empty,
  output logic          tx_not_full,
  output logic          rx_not_empty,
  output logic          rx_full,
  output logic          tx_err,
  output logic          rx_err,
  output logic [3:0]    ien,
  output logic [3:0]    int_stat,
  output logic          irq,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;

  assign tx_empty     = (tx_level == '0);
  assign tx_not_full  = (tx_level != LW'(DEPTH));
  assign rx_not_empty = (rx_level != '0);
  assign rx_full      = (rx_level == LW'(DEPTH));

  logic tx_wr, tx_rd, rx_wr, rx_rd;
  assign tx_wr = host_push & ~tx_flush & tx_not_full;
  assign tx_rd = per_pop   & ~tx_flush & ~tx_empty;
  assign rx_wr = per_push  & ~rx_flush & ~rx_full;
  assign rx_rd = host_pop  & ~rx_flush & rx_not_empty;

  logic tx_fault, rx_fault;
  assign tx_fault = ~tx_flush & ((host_push & ~tx_not_full) | (per_pop & tx_empty));
  assign rx_fault = ~rx_flush & per_push & rx_full;

  always_ff @(posedge clk) begin
    if (tx_wr) tx_mem[tx_wp] <= host_wdata;
    if (rx_wr) rx_mem[rx_wp] <= per_wdata;
  end

  assign tx_head = tx_mem[tx_rp];
  assign rx_head = rx_mem[rx_rp];

  always_ff @(posedge clk) begin
    if (!rst_n || tx_flush) begin
      tx_wp <= '0;
      tx_rp <= '0;
      tx_level <= '0;
    end else begin
      if (tx_wr) tx_wp <= tx_wp + AW'(1);
      if (tx_rd) tx_rp <= tx_rp + AW'(1);
      tx_level <= tx_level + LW'(tx_wr) - LW'(tx_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || rx_flush) begin
      rx_wp <= '0;
      rx_rp <= '0;
      rx_level <= '0;
    end else begin
      if (rx_wr) rx_wp <= rx_wp + AW'(1);
      if (rx_rd) rx_rp <= rx_rp + AW'(1);
      rx_level <= rx_level + LW'(rx_wr) - LW'(rx_rd);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_err <= 1'b0;
      rx_err <= 1'b0;
      ien    <= '0;
      irq    <= 1'b0;
    end else begin
      if (tx_fault)        tx_err <= 1'b1;
      else if (err_clr[0]) tx_err <= 1'b0;
      if (rx_fault)        rx_err <= 1'b1;
      else if (err_clr[1]) rx_err <= 1'b0;
      ien <= (ien & ~ien_clr) | ien_set;
      irq <= |int_stat;
    end
  end

  logic tx_trig, rx_trig;
  assign tx_trig = tx_lvl_en & (tx_level <= LW'(tx_thr));
  assign rx_trig = rx_lvl_en & (rx_level >= LW'(rx_thr) + LW'(1));

  assign int_stat   = {rx_trig, tx_trig, rx_err, tx_err} & ien;
  assign dma_tx_req = dma_tx_en & tx_not_full;
  assign dma_rx_req = dma_rx_en & rx_not_empty;

endmodule

module fifo_lvl_irq_chk #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_push,
  input logic          per_pop,
  input logic          per_push,
  input logic          tx_flush,
  input logic          rx_flush,
  input logic [1:0]    err_clr,
  input logic [3:0]    ien_set,
  input logic [3:0]    ien_clr,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          tx_empty,
  input logic          tx_not_full,
  input logic          rx_not_empty,
  input logic          rx_full,
  input logic          tx_err,
  input logic          rx_err,
  input logic [3:0]    ien,
  input logic [3:0]    int_stat,
  input logic          irq,
  input logic          dma_rx_req
);

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_level <= LW'(DEPTH) && rx_level <= LW'(DEPTH)); // R1

  AST_RX_FULL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    per_push && rx_full && !rx_flush |=> rx_err); // R4

  AST_TX_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err && !err_clr[0] |=> tx_err); // R5

  AST_IEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ien_clr[0] && !ien_set[0] |=> !ien[0]); // R6

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|int_stat) |=> irq); // R8

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(|int_stat) |=> !irq); // R8

  AST_DMA_RX_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dma_rx_req |-> rx_not_empty); // R9

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |=> tx_level == '0); // R10

  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_push && per_pop && !tx_flush && tx_not_full && !tx_empty |=> $stable(tx_level)); // R12

endmodule

bind fifo_lvl_irq fifo_lvl_irq_chk #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_push(host_push), .per_pop(per_pop),
  .per_push(per_push), .tx_flush(tx_flush), .rx_flush(rx_flush),
  .err_clr(err_clr), .ien_set(ien_set), .ien_clr(ien_clr),
  .tx_level(tx_level), .rx_level(rx_level), .tx_empty(tx_empty),
  .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty), .rx_full(rx_full),
  .tx_err(tx_err), .rx_err(rx_err), .ien(ien), .int_stat(int_stat),
  .irq(irq), .dma_rx_req(dma_rx_req)
);

// File: tb/fifo_lvl_irq_tb.sv
module fifo_lvl_irq_tb;
  localparam int DEPTH = 16;
  localparam int DW = 32;
  localparam int AW = 4;
  localparam int LW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n;
  logic host_push, host_pop, per_pop, per_push, tx_flush, rx_flush;
  logic [DW-1:0] host_wdata, per_wdata, rx_head, tx_head;
  logic [AW-1:0] tx_thr, rx_thr;
  logic tx_lvl_en, rx_lvl_en, dma_tx_en, dma_rx_en;
  logic [1:0] err_clr;
  logic [3:0] ien_set, ien_clr, ien, int_stat;
  logic [LW-1:0] tx_level, rx_level;
  logic tx_empty, tx_not_full, rx_not_empty, rx_full, tx_err, rx_err, irq;
  logic dma_tx_req, dma_rx_req;

  fifo_lvl_irq #(.DEPTH(DEPTH), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_push(host_push), .host_wdata(host_wdata),
    .host_pop(host_pop), .rx_head(rx_head), .per_pop(per_pop), .tx_head(tx_head),
    .per_push(per_push), .per_wdata(per_wdata), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_thr(tx_thr), .rx_thr(rx_thr), .tx_lvl_en(tx_lvl_en), .rx_lvl_en(rx_lvl_en),
    .dma_tx_en(dma_tx_en), .dma_rx_en(dma_rx_en), .err_clr(err_clr),
    .ien_set(ien_set), .ien_clr(ien_clr), .tx_level(tx_level), .rx_level(rx_level),
    .tx_empty(tx_empty), .tx_not_full(tx_not_full), .rx_not_empty(rx_not_empty),
    .rx_full(rx_full), .tx_err(tx_err), .rx_err(rx_err), .ien(ien),
    .int_stat(int_stat), .irq(irq), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // behavioural reference
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];
  logic m_txerr, m_rxerr, m_irq;
  logic [3:0] m_ien;

  function automatic logic [3:0] m_stat();
    logic tl, rl;
    tl = tx_lvl_en && (txq.size() <= int'(tx_thr));
    rl = rx_lvl_en && (rxq.size() >= int'(rx_thr) + 1);
    return {rl, tl, m_rxerr, m_txerr} & m_ien;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_txerr = 0; m_rxerr = 0; m_irq = 0; m_ien = 0;
    end else begin
      bit tset, rset, tfull, tempty, rfull, rempty;
      m_irq = |m_stat();
      tset = 0; rset = 0;
      if (tx_flush) txq.delete();
      else begin
        tfull = (txq.size() == DEPTH); tempty = (txq.size() == 0);
        if ((host_push && tfull) || (per_pop && tempty)) tset = 1;
        if (per_pop && !tempty) void'(txq.pop_front());
        if (host_push && !tfull) txq.push_back(host_wdata);
      end
      if (rx_flush) rxq.delete();
      else begin
        rfull = (rxq.size() == DEPTH); rempty = (rxq.size() == 0);
        if (per_push && rfull) rset = 1;
        if (host_pop && !rempty) void'(rxq.pop_front());
        if (per_push && !rfull) rxq.push_back(per_wdata);
      end
      if (tset) m_txerr = 1; else if (err_clr[0]) m_txerr = 0;
      if (rset) m_rxerr = 1; else if (err_clr[1]) m_rxerr = 0;
      m_ien = (m_ien & ~ien_clr) | ien_set;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R1 tx_level", 32'(tx_level), 32'(txq.size()));
      chk("R1 rx_level", 32'(rx_level), 32'(rxq.size()));
      chk("R1 tx_empty", 32'(tx_empty), 32'(txq.size() == 0));
      chk("R1 tx_not_full", 32'(tx_not_full), 32'(txq.size() < DEPTH));
      chk("R1 rx_not_empty", 32'(rx_not_empty), 32'(rxq.size() > 0));
      chk("R1 rx_full", 32'(rx_full), 32'(rxq.size() == DEPTH));
      if (txq.size() > 0) chk("R11 tx_head", tx_head, txq[0]);
      if (rxq.size() > 0) chk("R11 rx_head", rx_head, rxq[0]);
      chk("R4 tx_err", 32'(tx_err), 32'(m_txerr));
      chk("R4 rx_err", 32'(rx_err), 32'(m_rxerr));
      chk("R6 ien", 32'(ien), 32'(m_ien));
      chk("R7 int_stat", 32'(int_stat), 32'(m_stat()));
      chk("R8 irq", 32'(irq), 32'(m_irq));
      chk("R9 dma_tx_req", 32'(dma_tx_req), 32'(dma_tx_en && txq.size() < DEPTH));
      chk("R9 dma_rx_req", 32'(dma_rx_req), 32'(dma_rx_en && rxq.size() > 0));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic quiet();
    host_push = 0; host_pop = 0; per_pop = 0; per_push = 0;
    tx_flush = 0; rx_flush = 0; err_clr = 0; ien_set = 0; ien_clr = 0;
  endtask

  bit done = 0;

  task automatic run_main();
    rst_n = 0; quiet();
    host_wdata = 0; per_wdata = 0;
    tx_thr = 4; rx_thr = 2; tx_lvl_en = 0; rx_lvl_en = 0; dma_tx_en = 0; dma_rx_en = 0;
    repeat (3) tick();
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset tx_level", 32'(tx_level), 0);
    chk("R1 reset rx_level", 32'(rx_level), 0);
    chk("R8 reset irq", 32'(irq), 0);
    chk("R6 reset ien", 32'(ien), 0);
    tick();

    tx_lvl_en = 1; rx_lvl_en = 1; dma_tx_en = 1; dma_rx_en = 1;
    ien_set = 4'hF; tick(); quiet();

    for (int i = 0; i < 17; i++) begin
      host_push = 1; host_wdata = 32'(100 + i); tick();
    end
    quiet();
    @(negedge clk);
    chk("R4 level stays full", 32'(tx_level), 16);
    chk("R4 tx_err on full push", 32'(tx_err), 1);
    chk("R9 no tx request when full", 32'(dma_tx_req), 0);

    err_clr = 2'b01; host_push = 1; tick(); quiet();
    @(negedge clk);
    chk("R5 set wins over clear", 32'(tx_err), 1);
    err_clr = 2'b01; tick(); quiet();
    @(negedge clk);
    chk("R5 clear", 32'(tx_err), 0);

    per_pop = 1; tick(); quiet();
    host_push = 1; host_wdata = 32'd200; per_pop = 1; tick(); quiet();
    @(negedge clk);
    chk("R12 push+pop level", 32'(tx_level), 15);
    chk("R1 order head", tx_head, 102);
    chk("R12 no error", 32'(tx_err), 0);

    for (int i = 0; i < 10; i++) begin per_pop = 1; tick(); end
    quiet();
    @(negedge clk);
    chk("R2 level 5 above threshold", 32'(int_stat[2]), 0);
    per_pop = 1; tick(); quiet();
    @(negedge clk);
    chk("R2 level 4 reaches threshold", 32'(int_stat[2]), 1);

    tx_flush = 1; host_push = 1; host_wdata = 32'hDEAD; tick(); quiet();
    @(negedge clk);
    chk("R10 flush with push empties", 32'(tx_level), 0);
    chk("R10 no error on flush", 32'(tx_err), 0);
    per_pop = 1; tick(); quiet();
    @(negedge clk);
    chk("R4 pop from empty", 32'(tx_err), 1);
    err_clr = 2'b01; tick(); quiet();

    for (int i = 0; i < 2; i++) begin per_push = 1; per_wdata = 32'(8'hA0 + i); tick(); end
    quiet();
    @(negedge clk);
    chk("R3 two entries below", 32'(int_stat[3]), 0);
    per_push = 1; per_wdata = 32'hA2; tick(); quiet();
    @(negedge clk);
    chk("R3 three entries reach", 32'(int_stat[3]), 1);
    chk("R11 peek head", rx_head, 32'hA0);
    tick();
    @(negedge clk);
    chk("R11 peek keeps head", rx_head, 32'hA0);
    chk("R11 peek keeps level", 32'(rx_level), 3);
    host_pop = 1; tick(); quiet();
    @(negedge clk);
    chk("R11 pop advances", rx_head, 32'hA1);
    chk("R8 irq active", 32'(irq), 1);

    ien_clr = 4'hF; tick(); quiet();
    @(negedge clk);
    chk("R6 cleared", 32'(ien), 0);
    chk("R7 masked", 32'(int_stat), 0);
    chk("R8 irq one cycle late", 32'(irq), 1);
    tick();
    @(negedge clk);
    chk("R8 irq drops", 32'(irq), 0);
    ien_set = 4'h1; ien_clr = 4'h1; tick(); quiet();
    @(negedge clk);
    chk("R6 set wins", 32'(ien[0]), 1);

    for (int c = 0; c < 6000; c++) begin
      host_push  = ($urandom_range(0, 99) < 50);
      per_pop    = ($urandom_range(0, 99) < 45);
      per_push   = ($urandom_range(0, 99) < 50);
      host_pop   = ($urandom_range(0, 99) < 45);
      host_wdata = $urandom; per_wdata = $urandom;
      tx_flush   = ($urandom_range(0, 63) == 0);
      rx_flush   = ($urandom_range(0, 63) == 0);
      err_clr    = ($urandom_range(0, 15) == 0) ? 2'($urandom) : 2'b00;
      ien_set    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      ien_clr    = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'h0;
      if ($urandom_range(0, 99) == 0) begin
        tx_thr = 4'($urandom); rx_thr = 4'($urandom);
        tx_lvl_en = 1'($urandom); rx_lvl_en = 1'($urandom);
        dma_tx_en = 1'($urandom); dma_rx_en = 1'($urandom);
      end
      tick();
    end
    quiet();
    repeat (2) tick();
  endtask

  initial begin
    fork
      begin run_main(); done = 1; end
      begin
        repeat (150000) @(posedge clk);
        if (!done) begin
          n_chk++; n_err++;
          $display("FAIL watchdog expired actual=running expected=finished");
        end
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule